// File: doc/BRIEF.md
# Timer Configuration Register Bank with Enable Write Guard

This block is the configuration store of a timer/counter peripheral. A simple synchronous bus (address, write data, one full-word write strobe, combinational read data) reaches a main control word, a count-direction register with separate set and clear addresses, a waveform register, and five auxiliary configuration words: two fault control words, a waveform extension word, a drive control word and an event control word. Every stored field is brought out as a decoded configuration output for the counter core.

The bank guards configuration against change while the timer runs. The auxiliary words ignore writes while the timer is enabled. In the control word, every field except the enable bit is frozen while the timer is enabled. The guard looks at the enable state held before the write, not at the value being written. So one write can switch the timer on and load its settings in the same cycle. A write that switches the timer off cannot change those settings at the same time.

Top module: `tmr_cfg_bank`

## Requirements
- R1: While reset is asserted, and after it is released, every register reads 0 and every configuration output is 0, so the timer starts disabled.
- R2: Writes to the auxiliary words are dropped when the stored enable bit is 1 and stored in full when it is 0. The auxiliary words are fault A at address 3, fault B at 4, waveform extension at 5, drive control at 6 and event control at 7.
- R3: While the stored enable bit is 1, a write to the control word (address 0) changes only bit 1. Every other field keeps its value.
- R4: While the stored enable bit is 0, a control-word write with bit 1 set turns the timer on. The same write loads every control-word field from the written data.
- R5: While the stored enable bit is 1, a control-word write with bit 1 clear turns the timer off and leaves every other field unchanged.
- R6: The control word has the following layout. Bits not listed read 0.
  - enable: bit 1
  - resolution: [6:5]
  - run-in-standby: 7
  - prescaler: [10:8]
  - prescaler sync: [13:12]
  - auto-lock: 14
  - full-cycle: 15
  - DMA one-shot: 23
  - capture enable of channel n: 24+n
- R7: The waveform register (address 8) can be written at any time. Its mode select is bits [2:0] and the output polarity of channel y is bit 16+y. All other bits read 0.
- R8: The count direction is one register bit.
  - Writing 1 in bit 0 at address 2 selects down-counting (output 1).
  - Writing 1 in bit 0 at address 1 selects up-counting.
  - Zero bits have no effect.
  - Both addresses read the direction in bit 0, with all other bits 0.
- R9: The output invert enable of channel y is bit 16+y of the drive control word, and the whole drive word appears on its output.
- R10: Addresses 9 to 15 read 0, and writes to them change no register.
- R11: Reads return the stored value of every register whatever the enable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Full-word write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| cfg_enable | output | 1 | Timer enable |
| cfg_cap_en | output | NUM_CH | Per-channel capture enable |
| cfg_dma_oneshot | output | 1 | DMA one-shot trigger mode |
| cfg_full_cycle | output | 1 | Full-cycle mode |
| cfg_auto_lock | output | 1 | Auto-lock |
| cfg_presc_sync | output | 2 | Prescaler/counter sync select |
| cfg_run_stby | output | 1 | Run in standby |
| cfg_presc | output | 3 | Prescaler select |
| cfg_resolution | output | 2 | Enhanced resolution select |
| cfg_count_down | output | 1 | 1 = down-counting |
| cfg_wave_gen | output | 3 | Waveform generation mode |
| cfg_out_pol | output | NUM_CH | Per-channel output polarity |
| cfg_out_inv | output | NUM_CH | Per-channel output invert enable |
| cfg_fault_a | output | 32 | Fault control word A |
| cfg_fault_b | output | 32 | Fault control word B |
| cfg_wave_ext | output | 32 | Waveform extension word |
| cfg_drive | output | 32 | Drive control word |
| cfg_event | output | 32 | Event control word |

## Verification
The hardest cases to reach are the two edge writes. One is a single control-word write that turns the timer on while also carrying new protected field values. The other is a write that turns the timer off while carrying different field values, where the bank must keep the old ones. Random writes rarely hit the address with the right data pattern in the right stored state. Directed writes therefore set up each stored state first and then issue the edge write with field data that differs from the stored fields. Random traffic with bit 1 chosen freely then moves the bank through both states many times. After every write, all sixteen addresses are read back and compared with a bench model.

// File: rtl/tcb_pkg.sv
package tcb_pkg;
  localparam int DATA_W = 32;

  // address map
  localparam int unsigned ADR_CTRL   = 0;
  localparam int unsigned ADR_DIRCLR = 1;
  localparam int unsigned ADR_DIRSET = 2;
  localparam int unsigned AUX_BASE   = 3;
  localparam int unsigned AUX_N      = 5;
  localparam int unsigned ADR_WAVE   = 8;

  // auxiliary word order behind AUX_BASE
  localparam int unsigned AUX_FLTA = 0;
  localparam int unsigned AUX_FLTB = 1;
  localparam int unsigned AUX_WEXT = 2;
  localparam int unsigned AUX_DRV  = 3;
  localparam int unsigned AUX_EVT  = 4;

  // control word field positions
  localparam int EN_BIT    = 1;
  localparam int RES_LSB   = 5;
  localparam int RSTBY_BIT = 7;
  localparam int PRESC_LSB = 8;
  localparam int PSYNC_LSB = 12;
  localparam int ALOCK_BIT = 14;
  localparam int FCYC_BIT  = 15;
  localparam int DMAOS_BIT = 23;
  localparam int CAP_LSB   = 24;

  // waveform / drive word field positions
  localparam int WGEN_LSB = 0;
  localparam int POL_LSB  = 16;
  localparam int INV_LSB  = 16;

  function automatic logic [DATA_W-1:0] ctrl_impl_mask(int nch);
    logic [DATA_W-1:0] m;
    m = '0;
    m[EN_BIT]          = 1'b1;
    m[RES_LSB +: 2]    = 2'b11;
    m[RSTBY_BIT]       = 1'b1;
    m[PRESC_LSB +: 3]  = 3'b111;
    m[PSYNC_LSB +: 2]  = 2'b11;
    m[ALOCK_BIT]       = 1'b1;
    m[FCYC_BIT]        = 1'b1;
    m[DMAOS_BIT]       = 1'b1;
    for (int i = 0; i < nch; i++) m[CAP_LSB + i] = 1'b1;
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] ctrl_free_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    m[EN_BIT] = 1'b1;
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] wave_impl_mask(int nch);
    logic [DATA_W-1:0] m;
    m = '0;
    m[WGEN_LSB +: 3] = 3'b111;
    for (int i = 0; i < nch; i++) m[POL_LSB + i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/tcb_rst_sync.sv
module tcb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/tcb_reg.sv
module tcb_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_mask,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (wr_en) q_nxt = (q & ~wr_mask) | (wr_data & wr_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/tcb_wr_guard.sv
module tcb_wr_guard
  import tcb_pkg::*;
#(
  parameter int                ADDR_W    = 4,
  parameter logic [DATA_W-1:0] CTRL_IMPL = '1
) (
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                wdata_b0,
  input  logic                enable_q,
  output logic                ctrl_we,
  output logic [DATA_W-1:0]   ctrl_mask,
  output logic                wave_we,
  output logic                dir_we,
  output logic                dir_val,
  output logic [AUX_N-1:0]    aux_we
);
  localparam logic [DATA_W-1:0] FREE = ctrl_free_mask();

  logic hit_set, hit_clr;

  assign ctrl_we   = bus_we && (bus_addr == ADDR_W'(ADR_CTRL));
  // guard decided by the enable state held before this write
  assign ctrl_mask = enable_q ? (CTRL_IMPL & FREE) : CTRL_IMPL;
  assign wave_we   = bus_we && (bus_addr == ADDR_W'(ADR_WAVE));

  assign hit_set = bus_we && (bus_addr == ADDR_W'(ADR_DIRSET)) && wdata_b0;
  assign hit_clr = bus_we && (bus_addr == ADDR_W'(ADR_DIRCLR)) && wdata_b0;
  assign dir_we  = hit_set || hit_clr;
  assign dir_val = hit_set;

  for (genvar g = 0; g < AUX_N; g++) begin : g_aux_we
    assign aux_we[g] = bus_we && !enable_q &&
                       (bus_addr == ADDR_W'(AUX_BASE + g));
  end
endmodule

// File: rtl/tcb_rd_mux.sv
module tcb_rd_mux
  import tcb_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            ctrl_q,
  input  logic                         dir_q,
  input  logic [AUX_N-1:0][DATA_W-1:0] aux_q,
  input  logic [DATA_W-1:0]            wave_q,
  output logic [DATA_W-1:0]            rdata
);
  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(ADR_CTRL)) rdata = ctrl_q;
    if ((addr == ADDR_W'(ADR_DIRSET)) || (addr == ADDR_W'(ADR_DIRCLR)))
      rdata = {{(DATA_W-1){1'b0}}, dir_q};
    if (addr == ADDR_W'(ADR_WAVE)) rdata = wave_q;
    for (int g = 0; g < AUX_N; g++) begin
      if (addr == ADDR_W'(AUX_BASE + g)) rdata = aux_q[g];
    end
  end
endmodule

// File: rtl/tmr_cfg_bank.sv
module tmr_cfg_bank
  import tcb_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              cfg_enable,
  output logic [NUM_CH-1:0] cfg_cap_en,
  output logic              cfg_dma_oneshot,
  output logic              cfg_full_cycle,
  output logic              cfg_auto_lock,
  output logic [1:0]        cfg_presc_sync,
  output logic              cfg_run_stby,
  output logic [2:0]        cfg_presc,
  output logic [1:0]        cfg_resolution,
  output logic              cfg_count_down,
  output logic [2:0]        cfg_wave_gen,
  output logic [NUM_CH-1:0] cfg_out_pol,
  output logic [NUM_CH-1:0] cfg_out_inv,
  output logic [31:0]       cfg_fault_a,
  output logic [31:0]       cfg_fault_b,
  output logic [31:0]       cfg_wave_ext,
  output logic [31:0]       cfg_drive,
  output logic [31:0]       cfg_event
);
  localparam logic [DATA_W-1:0] CTRL_MASK = ctrl_impl_mask(NUM_CH);
  localparam logic [DATA_W-1:0] WAVE_MASK = wave_impl_mask(NUM_CH);

  logic                         rst_n_int;
  logic                         ctrl_we, wave_we, dir_we, dir_val;
  logic [DATA_W-1:0]            ctrl_mask;
  logic [AUX_N-1:0]             aux_we;
  logic [DATA_W-1:0]            ctrl_q, wave_q;
  logic [AUX_N-1:0][DATA_W-1:0] aux_q;
  logic                         dir_q;

  tcb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  tcb_wr_guard #(.ADDR_W(ADDR_W), .CTRL_IMPL(CTRL_MASK)) u_guard (
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .wdata_b0  (bus_wdata[0]),
    .enable_q  (ctrl_q[EN_BIT]),
    .ctrl_we   (ctrl_we),
    .ctrl_mask (ctrl_mask),
    .wave_we   (wave_we),
    .dir_we    (dir_we),
    .dir_val   (dir_val),
    .aux_we    (aux_we)
  );

  tcb_reg #(.W(DATA_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .wr_en   (ctrl_we),
    .wr_mask (ctrl_mask),
    .wr_data (bus_wdata),
    .q       (ctrl_q)
  );

  tcb_reg #(.W(1)) u_dir (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .wr_en   (dir_we),
    .wr_mask (1'b1),
    .wr_data (dir_val),
    .q       (dir_q)
  );

  tcb_reg #(.W(DATA_W)) u_wave (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .wr_en   (wave_we),
    .wr_mask (WAVE_MASK),
    .wr_data (bus_wdata),
    .q       (wave_q)
  );

  for (genvar g = 0; g < AUX_N; g++) begin : g_aux
    tcb_reg #(.W(DATA_W)) u_aux (
      .clk     (clk),
      .rst_n   (rst_n_int),
      .wr_en   (aux_we[g]),
      .wr_mask ({DATA_W{1'b1}}),
      .wr_data (bus_wdata),
      .q       (aux_q[g])
    );
  end

  tcb_rd_mux #(.ADDR_W(ADDR_W)) u_rd (
    .addr   (bus_addr),
    .ctrl_q (ctrl_q),
    .dir_q  (dir_q),
    .aux_q  (aux_q),
    .wave_q (wave_q),
    .rdata  (bus_rdata)
  );

  // decoded configuration towards the counter core
  assign cfg_enable      = ctrl_q[EN_BIT];
  assign cfg_cap_en      = ctrl_q[CAP_LSB +: NUM_CH];
  assign cfg_dma_oneshot = ctrl_q[DMAOS_BIT];
  assign cfg_full_cycle  = ctrl_q[FCYC_BIT];
  assign cfg_auto_lock   = ctrl_q[ALOCK_BIT];
  assign cfg_presc_sync  = ctrl_q[PSYNC_LSB +: 2];
  assign cfg_run_stby    = ctrl_q[RSTBY_BIT];
  assign cfg_presc       = ctrl_q[PRESC_LSB +: 3];
  assign cfg_resolution  = ctrl_q[RES_LSB +: 2];
  assign cfg_count_down  = dir_q;
  assign cfg_wave_gen    = wave_q[WGEN_LSB +: 3];
  assign cfg_out_pol     = wave_q[POL_LSB +: NUM_CH];
  assign cfg_fault_a     = aux_q[AUX_FLTA];
  assign cfg_fault_b     = aux_q[AUX_FLTB];
  assign cfg_wave_ext    = aux_q[AUX_WEXT];
  assign cfg_drive       = aux_q[AUX_DRV];
  assign cfg_out_inv     = aux_q[AUX_DRV][INV_LSB +: NUM_CH];
  assign cfg_event       = aux_q[AUX_EVT];
endmodule

// File: rtl/tcb_chk.sv
module tcb_chk #(
  parameter int ADDR_W = 4,
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              cfg_enable,
  input logic [NUM_CH-1:0] cfg_cap_en,
  input logic              cfg_dma_oneshot,
  input logic              cfg_full_cycle,
  input logic              cfg_auto_lock,
  input logic [1:0]        cfg_presc_sync,
  input logic              cfg_run_stby,
  input logic [2:0]        cfg_presc,
  input logic [1:0]        cfg_resolution,
  input logic              cfg_count_down,
  input logic [2:0]        cfg_wave_gen,
  input logic [NUM_CH-1:0] cfg_out_pol,
  input logic [31:0]       cfg_fault_a,
  input logic [31:0]       cfg_fault_b,
  input logic [31:0]       cfg_wave_ext,
  input logic [31:0]       cfg_drive,
  input logic [31:0]       cfg_event
);
  logic past_ok;
  logic [NUM_CH+14:0] prot;
  logic [159:0]       aux;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assign prot = {cfg_cap_en, cfg_dma_oneshot, cfg_full_cycle, cfg_auto_lock,
                 cfg_presc_sync, cfg_run_stby, cfg_presc, cfg_resolution};
  assign aux  = {cfg_fault_a, cfg_fault_b, cfg_wave_ext, cfg_drive, cfg_event};

  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (!cfg_enable && prot == '0 && aux == '0 &&
                                     !cfg_count_down && cfg_wave_gen == '0 &&
                                     cfg_out_pol == '0);
    end
  end

  // R3 and R5: protected fields frozen while enabled
  assert_prot_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(cfg_enable)) |-> (prot == $past(prot)));

  assert_aux_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(cfg_enable)) |-> (aux == $past(aux)));

  assert_enable_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(bus_we && bus_addr == '0 && !cfg_enable && bus_wdata[1]))
    |-> (cfg_enable && cfg_presc == $past(bus_wdata[10:8]) &&
         cfg_cap_en == $past(bus_wdata[24 +: NUM_CH])));

  assert_disable_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(bus_we && bus_addr == '0 && !bus_wdata[1])) |-> !cfg_enable);

  assert_dir_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(bus_we && bus_addr == ADDR_W'(2) && bus_wdata[0])) |-> cfg_count_down);

  assert_dir_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(bus_we && bus_addr == ADDR_W'(1) && bus_wdata[0])) |-> !cfg_count_down);

  assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(bus_we && bus_addr > ADDR_W'(8)))
    |-> ($stable(prot) && $stable(aux) && $stable(cfg_enable) &&
         $stable(cfg_count_down) && $stable(cfg_wave_gen) && $stable(cfg_out_pol)));
endmodule

bind tmr_cfg_bank tcb_chk #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n_int),
  .bus_we          (bus_we),
  .bus_addr        (bus_addr),
  .bus_wdata       (bus_wdata),
  .cfg_enable      (cfg_enable),
  .cfg_cap_en      (cfg_cap_en),
  .cfg_dma_oneshot (cfg_dma_oneshot),
  .cfg_full_cycle  (cfg_full_cycle),
  .cfg_auto_lock   (cfg_auto_lock),
  .cfg_presc_sync  (cfg_presc_sync),
  .cfg_run_stby    (cfg_run_stby),
  .cfg_presc       (cfg_presc),
  .cfg_resolution  (cfg_resolution),
  .cfg_count_down  (cfg_count_down),
  .cfg_wave_gen    (cfg_wave_gen),
  .cfg_out_pol     (cfg_out_pol),
  .cfg_fault_a     (cfg_fault_a),
  .cfg_fault_b     (cfg_fault_b),
  .cfg_wave_ext    (cfg_wave_ext),
  .cfg_drive       (cfg_drive),
  .cfg_event       (cfg_event)
);

// File: tb/test_tmr_cfg_bank.sv
`timescale 1ns/1ps
module test_tmr_cfg_bank;
  localparam int ADDR_W = 4;
  localparam int NUM_CH = 8;
  localparam logic [31:0] CTRL_MASK = 32'hFF80_F7E2; // R6 layout
  localparam logic [31:0] WAVE_MASK = 32'h00FF_0007; // R7 layout

  logic              clk = 1'b0;
  logic              rst_n;
  logic              bus_we;
  logic [ADDR_W-1:0] bus_addr;
  logic [31:0]       bus_wdata;
  logic [31:0]       bus_rdata;
  logic              cfg_enable, cfg_dma_oneshot, cfg_full_cycle, cfg_auto_lock;
  logic              cfg_run_stby, cfg_count_down;
  logic [NUM_CH-1:0] cfg_cap_en, cfg_out_pol, cfg_out_inv;
  logic [1:0]        cfg_presc_sync, cfg_resolution;
  logic [2:0]        cfg_presc, cfg_wave_gen;
  logic [31:0]       cfg_fault_a, cfg_fault_b, cfg_wave_ext, cfg_drive, cfg_event;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [31:0] m_ctrl, m_wave;
  logic        m_dir;
  logic [31:0] m_aux [5];

  always #4 clk = ~clk;

  tmr_cfg_bank #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) i_tmr_cfg_bank (.*);

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(int a);
    if (a == 0) return m_ctrl;
    if (a == 1 || a == 2) return {31'b0, m_dir};
    if (a >= 3 && a <= 7) return m_aux[a-3];
    if (a == 8) return m_wave;
    return 32'h0;
  endfunction

  function automatic string req_of(int a);
    if (a == 0) return "R6";
    if (a == 1 || a == 2) return "R8";
    if (a >= 3 && a <= 7) return "R2";
    if (a == 8) return "R7";
    return "R10";
  endfunction

  task automatic model_wr(int a, logic [31:0] d);
    logic [31:0] keep;
    if (a == 0) begin
      keep   = m_ctrl[1] ? 32'h0000_0002 : CTRL_MASK;
      m_ctrl = (m_ctrl & ~keep) | (d & keep);
    end else if (a == 1) begin
      if (d[0]) m_dir = 1'b0;
    end else if (a == 2) begin
      if (d[0]) m_dir = 1'b1;
    end else if (a >= 3 && a <= 7) begin
      if (!m_ctrl[1]) m_aux[a-3] = d;
    end else if (a == 8) begin
      m_wave = d & WAVE_MASK;
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_we    = 1'b1;
    bus_addr  = ADDR_W'(a);
    bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    model_wr(a, d);
  endtask

  task automatic rd_all(string tag);
    for (int a = 0; a < 16; a++) begin
      bus_addr = ADDR_W'(a);
      #1;
      chk(tag.len() > 0 ? tag : req_of(a), $sformatf("read addr %0d", a), bus_rdata, exp_rd(a));
    end
  endtask

  task automatic chk_outs();
    chk("R6", "enable",     {31'b0, cfg_enable},      {31'b0, m_ctrl[1]});
    chk("R6", "ctrl fields",
        {cfg_cap_en, cfg_dma_oneshot, cfg_full_cycle, cfg_auto_lock, cfg_presc_sync,
         1'b0, cfg_presc, cfg_run_stby, cfg_resolution, 5'b0},
        {m_ctrl[31:24], m_ctrl[23], m_ctrl[15], m_ctrl[14], m_ctrl[13:12],
         1'b0, m_ctrl[10:8], m_ctrl[7], m_ctrl[6:5], 5'b0});
    chk("R8", "count_down", {31'b0, cfg_count_down},  {31'b0, m_dir});
    chk("R7", "wave out",   {8'b0, cfg_out_pol, 13'b0, cfg_wave_gen},
        {8'b0, m_wave[23:16], 13'b0, m_wave[2:0]});
    chk("R9", "out_inv",    {24'b0, cfg_out_inv},     {24'b0, m_aux[3][23:16]});
    chk("R2", "aux outs",   cfg_fault_a ^ cfg_fault_b ^ cfg_wave_ext ^ cfg_drive ^ cfg_event,
        m_aux[0] ^ m_aux[1] ^ m_aux[2] ^ m_aux[3] ^ m_aux[4]);
    chk("R9", "drive",      cfg_drive,                m_aux[3]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    m_ctrl = '0; m_wave = '0; m_dir = 1'b0;
    for (int i = 0; i < 5; i++) m_aux[i] = '0;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rd_all("R1");
    chk("R1", "enable in reset", {31'b0, cfg_enable}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd_all("R1");
    chk_outs();

    // R6: load fields while disabled, enable left 0
    wr(0, 32'hFFFF_FFFD);
    rd_all(""); chk_outs();
    chk("R6", "ctrl read mask", bus_rdata, 32'h0); // addr 15 still selected
    // R2: aux written while disabled
    for (int a = 3; a <= 7; a++) wr(a, 32'h1111_0000 * a + 32'h00A5);
    wr(6, 32'h00C3_5A5A);
    rd_all(""); chk_outs();
    chk("R9", "invert field", {24'b0, cfg_out_inv}, 32'h0000_00C3);
    // R4: enabling write loads new fields
    wr(0, 32'h5A80_A3A2);
    rd_all("R4"); chk_outs();
    chk("R4", "presc after enable", {29'b0, cfg_presc}, 32'h3);
    // R3: write while enabled only touches enable
    wr(0, 32'h0000_0002);
    rd_all("R3");
    chk("R3", "cap_en frozen", {24'b0, cfg_cap_en}, 32'h5A);
    // R2 / R11: aux writes dropped while enabled; reads still work
    for (int a = 3; a <= 7; a++) wr(a, 32'hDEAD_BEEF);
    rd_all("R11"); chk_outs();
    chk("R2", "drive kept", cfg_drive, 32'h00C3_5A5A);
    // R7: wave writable while enabled
    wr(8, 32'hFFFF_FFFF);
    rd_all("R7"); chk_outs();
    // R5: disabling write leaves protected fields
    wr(0, 32'h0000_1500);
    rd_all("R5");
    chk("R5", "enable off", {31'b0, cfg_enable}, 32'h0);
    chk("R5", "presc kept", {29'b0, cfg_presc}, 32'h3);
    // R8: direction set/clear and zero writes
    wr(2, 32'hFFFF_FFFE); chk("R8", "set zero bit", {31'b0, cfg_count_down}, 32'h0);
    wr(2, 32'h1);         chk("R8", "set",          {31'b0, cfg_count_down}, 32'h1);
    wr(1, 32'hFFFF_FFFE); chk("R8", "clr zero bit", {31'b0, cfg_count_down}, 32'h1);
    rd_all("R8");
    wr(1, 32'h1);         chk("R8", "clr",          {31'b0, cfg_count_down}, 32'h0);
    // R10: unmapped addresses
    for (int a = 9; a < 16; a++) wr(a, 32'hFFFF_FFFF);
    rd_all("R10"); chk_outs();

    // random traffic
    for (int n = 0; n < 600; n++) begin
      int a;
      logic [31:0] d;
      a = int'($urandom % 16);
      if (($urandom % 3) == 0) a = 0;
      d = $urandom;
      wr(a, d);
      rd_all(""); chk_outs();
    end
    finish_run();
  end
endmodule